// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds eight 32-bit general registers behind one write port and two read ports. Every access carries a two-bit view selector, so a caller can work on a whole register, on its low 16 bits, or on a single byte. Byte views exist only for the first four registers. For each of them, one code picks bits 7:0 and a second code picks bits 15:8. Two registers together can hold a 64-bit quantity, with one of them taken as the upper half. Software sees this as an ordinary pairing convention; the block itself needs nothing extra for it.

A narrow write merges into its register: only the addressed bits change and the rest keep their old contents. A narrow read returns the selected field with zeros above it. The two read ports are combinational. A write takes effect at the rising clock edge, so a read of the register being written in that same cycle still sees the old contents. A synchronous active-high reset clears every register.

Top module: `partial_regfile`

## Requirements
- R1: While reset is high at a rising edge, every register becomes zero, and a full-view read of any register then returns 0.
- R2: A write with wr_en high and view code 2'b00 (full), or the spare code 2'b11 (also full), replaces all 32 bits of register wr_idx at the rising edge.
- R3: A write with view code 2'b01 (half) replaces bits 15:0 of register wr_idx and keeps bits 31:16 unchanged.
- R4: A write with view code 2'b10 (byte) and index 0 to 3 replaces bits 7:0 of register index; bits 31:8 keep their value.
- R5: A byte-view write with index 4 to 7 replaces bits 15:8 of register index-4 and keeps its bits 31:16 and 7:0; no byte-view write ever changes registers 4 to 7.
- R6: A half-view read (code 2'b01) returns bits 15:0 of the register, zero-extended to 32 bits.
- R7: A byte-view read (code 2'b10) returns bits 7:0 of register index for index 0 to 3, and bits 15:8 of register index-4 for index 4 to 7, zero-extended to 32 bits.
- R8: The two read ports take their own index and view code and can read different registers, or the same one, in the same cycle.
- R9: A read of the register being written in the same cycle returns its old contents; the new value is visible from the next cycle.
- R10: With wr_en low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register or byte code |
| wr_size | input | 2 | Write view: 00 full, 01 half, 10 byte, 11 full |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| ra_idx | input | 3 | Read port A register or byte code |
| ra_size | input | 2 | Read port A view code |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_idx | input | 3 | Read port B register or byte code |
| rb_size | input | 2 | Read port B view code |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
A write and a read of the same register can fall in the same cycle, and a byte write to one half of a register can meet a read of its other byte. The bench drives both read ports at the register being written in that very cycle. It expects the old contents then and the merged value in the next cycle. Byte and half writes are placed over known full patterns, so every bit that must survive a merge is seen on a port.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int DW     = 32;
    localparam int NREG   = 8;
    localparam int NBREG  = 4;
    localparam int BW     = 8;
    localparam int HW     = DW / 2;
    localparam int IDXW   = $clog2(NREG);
    localparam int BSELW  = $clog2(NBREG);
    localparam int NRD    = 2;

    typedef enum logic [1:0] {
        VIEW_FULL = 2'b00,
        VIEW_HALF = 2'b01,
        VIEW_BYTE = 2'b10,
        VIEW_ALT  = 2'b11
    } view_e;

    typedef struct packed {
        logic [IDXW-1:0] phys;
        view_e           view;
        logic            hi;
    } target_t;

    function automatic target_t decode_target(logic [IDXW-1:0] code, logic [1:0] sz);
        target_t t;
        t.view = view_e'(sz);
        t.phys = code;
        t.hi   = 1'b0;
        if (t.view == VIEW_BYTE) begin
            t.phys = IDXW'(code[BSELW-1:0]);
            t.hi   = code[BSELW];
        end
        return t;
    endfunction

    function automatic logic [DW-1:0] merge_view(logic [DW-1:0] old_v,
                                                 logic [DW-1:0] din,
                                                 target_t t);
        logic [DW-1:0] r;
        case (t.view)
            VIEW_HALF: r = {old_v[DW-1:HW], din[HW-1:0]};
            VIEW_BYTE: begin
                if (t.hi) r = {old_v[DW-1:2*BW], din[BW-1:0], old_v[BW-1:0]};
                else      r = {old_v[DW-1:BW], din[BW-1:0]};
            end
            default:   r = din;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] extract_view(logic [DW-1:0] v, target_t t);
        logic [DW-1:0] r;
        case (t.view)
            VIEW_HALF: r = DW'(v[HW-1:0]);
            VIEW_BYTE: begin
                if (t.hi) r = DW'(v[2*BW-1:BW]);
                else      r = DW'(v[BW-1:0]);
            end
            default:   r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpr_wr_merge.sv
module gpr_wr_merge
    import gpr_pkg::*;
(
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] din,
    input  target_t       tgt,
    output logic [DW-1:0] new_val
);

    always_comb begin
        new_val = merge_view(old_val, din, tgt);
    end

endmodule

// File: rtl/gpr_rd_view.sv
module gpr_rd_view
    import gpr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] reg_val,
    input  target_t       tgt,
    output logic [DW-1:0] dout
);

    always_comb begin
        dout = extract_view(reg_val, tgt);
    end

    // R6
    half_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt.view == VIEW_HALF) |-> (dout[DW-1:HW] == '0 && dout[HW-1:0] == reg_val[HW-1:0]));

    // R7
    byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt.view == VIEW_BYTE) |-> (dout[DW-1:BW] == '0));

endmodule

// File: rtl/partial_regfile.sv
module partial_regfile
    import gpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_size,
    input  logic [DW-1:0]   wr_data,
    input  logic [IDXW-1:0] ra_idx,
    input  logic [1:0]      ra_size,
    output logic [DW-1:0]   ra_data,
    input  logic [IDXW-1:0] rb_idx,
    input  logic [1:0]      rb_size,
    output logic [DW-1:0]   rb_data
);

    logic [NREG-1:0][DW-1:0] regs;

    target_t         wt;
    logic [IDXW-1:0] wr_phys;
    logic [DW-1:0]   wr_old;
    logic [DW-1:0]   wr_new;

    always_comb begin
        wt      = decode_target(wr_idx, wr_size);
        wr_phys = wt.phys;
        wr_old  = regs[wr_phys];
    end

    gpr_wr_merge u_merge (
        .old_val (wr_old),
        .din     (wr_data),
        .tgt     (wt),
        .new_val (wr_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            regs[wr_phys] <= wr_new;
        end
    end

    logic [NRD-1:0][IDXW-1:0] rd_code;
    logic [NRD-1:0][1:0]      rd_sz;
    logic [NRD-1:0][DW-1:0]   rd_out;

    assign rd_code = {rb_idx, ra_idx};
    assign rd_sz   = {rb_size, ra_size};
    assign ra_data = rd_out[0];
    assign rb_data = rd_out[1];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        target_t       rt;
        logic [DW-1:0] rsel;
        always_comb begin
            rt   = decode_target(rd_code[p], rd_sz[p]);
            rsel = regs[rt.phys];
        end
        gpr_rd_view u_view (
            .clk     (clk),
            .rst     (rst),
            .reg_val (rsel),
            .tgt     (rt),
            .dout    (rd_out[p])
        );
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wt.view == VIEW_FULL || wt.view == VIEW_ALT))
        |=> regs[$past(wr_phys)] == $past(wr_data));

    // R3
    half_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wt.view == VIEW_HALF)
        |=> regs[$past(wr_phys)][DW-1:HW] == $past(wr_old[DW-1:HW]));

    // R4
    byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wt.view == VIEW_BYTE)
        |=> regs[$past(wr_phys)][DW-1:2*BW] == $past(wr_old[DW-1:2*BW]));

    // R5
    byte_spare_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wt.view == VIEW_BYTE)
        |=> regs[NREG-1:NBREG] == $past(regs[NREG-1:NBREG]));

endmodule

// File: tb/sim_partial_regfile.sv
module sim_partial_regfile;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  ra_idx = '0;
    logic [1:0]  ra_size = '0;
    logic [31:0] ra_data;
    logic [2:0]  rb_idx = '0;
    logic [1:0]  rb_size = '0;
    logic [31:0] rb_data;

    always #(PER/2) clk = ~clk;

    partial_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_size(wr_size), .wr_data(wr_data),
        .ra_idx(ra_idx), .ra_size(ra_size), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_size(rb_size), .rb_data(rb_data)
    );

    typedef struct {
        string       tag;
        logic [31:0] ea;
        logic [31:0] eb;
    } item_t;

    item_t       q[$];
    logic [31:0] model [8];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    function automatic logic [31:0] bview(int code, bit [1:0] sz);
        logic [31:0] v;
        if (sz == 2'b10) begin
            v = model[code % 4];
            return (code >= 4) ? {24'h0, v[15:8]} : {24'h0, v[7:0]};
        end
        v = model[code];
        if (sz == 2'b01) return {16'h0, v[15:0]};
        return v;
    endfunction

    task automatic cyc(string tag, bit we, int widx, bit [1:0] wsz, logic [31:0] wd,
                       int ai, bit [1:0] asz, int bi, bit [1:0] bsz);
        item_t it;
        @(negedge clk);
        wr_en = we; wr_idx = 3'(widx); wr_size = wsz; wr_data = wd;
        ra_idx = 3'(ai); ra_size = asz; rb_idx = 3'(bi); rb_size = bsz;
        it.tag = tag;
        it.ea  = bview(ai, asz);
        it.eb  = bview(bi, bsz);
        q.push_back(it);
        if (we) begin
            if (wsz == 2'b01) model[widx][15:0] = wd[15:0];
            else if (wsz == 2'b10) begin
                if (widx >= 4) model[widx-4][15:8] = wd[7:0];
                else           model[widx][7:0]   = wd[7:0];
            end else model[widx] = wd;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #(PER/4);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks += 2;
                if (ra_data !== it.ea) begin
                    errors++;
                    $display("FAIL %s port A actual %h expected %h", it.tag, ra_data, it.ea);
                end
                if (rb_data !== it.eb) begin
                    errors++;
                    $display("FAIL %s port B actual %h expected %h", it.tag, rb_data, it.eb);
                end
            end
        end
    end

    initial begin : watchdog
        #(PER * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state of all registers
        for (int i = 0; i < 8; i += 2) cyc("R1", 0, 0, 2'b00, 0, i, 2'b00, i+1, 2'b00);
        // R2 full writes, R9 same-cycle read returns old contents
        for (int i = 0; i < 8; i++)
            cyc("R2_R9", 1, i, (i % 2) ? 2'b11 : 2'b00, 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1)),
                i, 2'b00, (i + 7) % 8, 2'b00);
        for (int i = 0; i < 8; i += 2) cyc("R2", 0, 0, 2'b00, 0, i, 2'b00, i+1, 2'b00);
        // R3 half write keeps upper half, R6 half read
        cyc("R3", 1, 5, 2'b01, 32'hDEAD_BEEF, 5, 2'b00, 5, 2'b01);
        cyc("R3_R6", 0, 0, 2'b00, 0, 5, 2'b00, 5, 2'b01);
        // R4 low byte write
        cyc("R4", 1, 2, 2'b10, 32'hFFFF_FF3C, 2, 2'b00, 6, 2'b10);
        cyc("R4", 0, 0, 2'b00, 0, 2, 2'b00, 2, 2'b10);
        // R5 high byte write into register 2, registers 4-7 untouched
        cyc("R5", 1, 6, 2'b10, 32'h0000_0081, 2, 2'b00, 6, 2'b00);
        cyc("R5", 0, 0, 2'b00, 0, 2, 2'b00, 6, 2'b00);
        cyc("R5", 1, 4, 2'b10, 32'h0000_00E7, 0, 2'b00, 4, 2'b00);
        cyc("R5", 0, 0, 2'b00, 0, 0, 2'b00, 4, 2'b00);
        // R7 byte reads of every code
        for (int i = 0; i < 8; i += 2) cyc("R7", 0, 0, 2'b00, 0, i, 2'b10, i+1, 2'b10);
        // R6 half reads on all registers, R8 distinct ports
        for (int i = 0; i < 8; i++) cyc("R6_R8", 0, 0, 2'b00, 0, i, 2'b01, 7 - i, 2'b00);
        // R10 disabled write
        cyc("R10", 0, 3, 2'b00, 32'h1234_5678, 3, 2'b00, 3, 2'b01);
        cyc("R10", 0, 7, 2'b10, 32'hFFFF_FFFF, 3, 2'b00, 7, 2'b10);
        // R9 byte write with both ports on the target
        cyc("R9", 1, 7, 2'b10, 32'h0000_0055, 3, 2'b00, 7, 2'b10);
        cyc("R9", 0, 0, 2'b00, 0, 3, 2'b00, 7, 2'b10);
        // R1 reset mid-run
        do_reset();
        for (int i = 0; i < 8; i += 2) cyc("R1", 0, 0, 2'b00, 0, i, 2'b00, i+1, 2'b00);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule